// File: doc/BRIEF.md
# Memory Bit Set, Clear and Test Sequencer

The block performs single-bit read-modify-write operations on a byte-wide memory. A request names one of four operations: set a bit, clear a bit, test a bit in memory, or test a register operand against an immediate mask. It also names a bit position and an address, and is taken in with a start strobe. The memory address is formed in one of three ways: an 8-bit offset added to a fixed I/O region base, an 8-bit absolute address, or a full 16-bit absolute address.

For set and clear, the addressed byte is read first. It is ANDed with a one-hot mask built from the bit position, and the zero and negative flags come from that masked value. The byte is then written back with the selected bit forced high for set or low for clear. The memory test performs only the read and the flag update. The register test ANDs a data operand with an 8-bit immediate and touches no memory. Every operation leaves the carry and overflow flags cleared. A one-cycle `done_o` pulse marks the moment the new flags become valid. A new request may be presented in that cycle.

Top module: `bit_rmw_seq`

## Requirements
- R1: After reset, `done_o`, `busy_o`, `mem_rd_o`, `mem_wr_o`, `zf_o`, `nf_o`, `cf_o` and `vf_o` are all 0.
- R2: The memory address is formed from `mode_i`. Code 2'b00 gives `IO_BASE` plus `addr_i[7:0]`, modulo 2^16. Code 2'b01 gives `addr_i[7:0]` zero-extended. Codes 2'b10 and 2'b11 give `addr_i` unchanged. The read and any write use this address.
- R3: At `done_o`, `zf_o` is 1 exactly when (operand AND mask) is zero, and `nf_o` equals bit 7 of that masked value. Both `cf_o` and `vf_o` are 0. For memory operations the operand is the byte as read, before any change, and the mask is 1 shifted left by `bitpos_i`.
- R4: Operation code 2'b00 (set) performs one read and then exactly one write, to the same address, of the read byte OR mask.
- R5: Operation code 2'b01 (clear) performs one read and then exactly one write, to the same address, of the read byte AND NOT mask.
- R6: Operation code 2'b10 (memory test) performs one read, no write, and leaves memory unchanged.
- R7: Operation code 2'b11 (register test) uses `reg_i` AND `imm_i` as the masked value. It makes no memory access and raises `done_o` in the cycle after the accepting edge.
- R8: `mem_rd_o` is high in the cycle after the accepting edge, and read data is taken one cycle after the read. `done_o` rises 4 cycles after the accepting edge for set and clear, and 3 cycles after it for the memory test. It stays high for one cycle unless a register test is accepted back-to-back.
- R9: A start request presented while `busy_o` is high is ignored. It causes no further memory access and does not alter the running operation.
- R10: A start request presented in a `done_o` cycle is accepted, so operations can run back-to-back without an idle cycle.
- R11: `zf_o` and `nf_o` change only on the edge that raises `done_o`, and they hold their values between operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, taken when idle or in the done cycle |
| op_i | input | 2 | 00 set, 01 clear, 10 memory test, 11 register test |
| mode_i | input | 2 | 00 I/O relative, 01 absolute 8-bit, 1x absolute 16-bit |
| bitpos_i | input | 3 | Selected bit position |
| addr_i | input | 16 | Address or I/O offset (low 8 bits) |
| reg_i | input | 8 | Register operand for the register test |
| imm_i | input | 8 | Immediate mask for the register test |
| busy_o | output | 1 | Memory operation in progress |
| done_o | output | 1 | Operation complete, flags valid |
| zf_o | output | 1 | Zero flag |
| nf_o | output | 1 | Negative flag |
| cf_o | output | 1 | Carry flag |
| vf_o | output | 1 | Overflow flag |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the read |

## Verification
Two events can share a cycle: the completion of one operation (done pulse and flag update) and the acceptance of the next request. The bench launches each request in the very negedge where it sees `done_o` high for about half the runs, and leaves an idle cycle for the rest. It then compares the next operation's read address, write data and flags, and the held flags after idle gaps, against values it works out from the mask arithmetic. A second collision comes from raising a competing start while the unit is busy. The judge is that the read and write counts for that run stay at one each and that the write goes to the original address.

// File: rtl/bit_rmw_pkg.sv
package bit_rmw_pkg;

    typedef enum logic [1:0] {
        OP_SET  = 2'b00,
        OP_CLR  = 2'b01,
        OP_TSTM = 2'b10,
        OP_TSTR = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        AM_IO    = 2'b00,
        AM_ABS8  = 2'b01,
        AM_ABS16 = 2'b10,
        AM_ABSX  = 2'b11
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_WRITE = 3'd3,
        ST_DONE  = 3'd4
    } state_e;

endpackage

// File: rtl/bit_rmw_addr.sv
module bit_rmw_addr
    import bit_rmw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFFS_W = 8,
    parameter logic [ADDR_W-1:0] IO_BASE = 16'h3F80
) (
    input  amode_e            mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] ea_o
);

    localparam int PAD_W = ADDR_W - OFFS_W;

    logic [ADDR_W-1:0] short_addr;

    // Zero-extended short form, shared by the I/O and 8-bit absolute modes.
    assign short_addr = {{PAD_W{1'b0}}, addr_i[OFFS_W-1:0]};

    always_comb begin
        unique case (mode_i)
            AM_IO:   ea_o = IO_BASE + short_addr;
            AM_ABS8: ea_o = short_addr;
            default: ea_o = addr_i;
        endcase
    end

endmodule

// File: rtl/bit_rmw_bitlogic.sv
module bit_rmw_bitlogic #(
    parameter int DATA_W = 8,
    parameter int POS_W  = $clog2(DATA_W)
) (
    input  logic [POS_W-1:0]  pos_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [DATA_W-1:0] alt_mask_i,
    input  logic              use_alt_i,
    output logic [DATA_W-1:0] set_val_o,
    output logic [DATA_W-1:0] clr_val_o,
    output logic              zf_o,
    output logic              nf_o
);

    logic [DATA_W-1:0] onehot;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] masked;

    // One decoder line per bit position.
    for (genvar g = 0; g < DATA_W; g++) begin : g_dec
        assign onehot[g] = (pos_i == POS_W'(g));
    end

    assign mask      = use_alt_i ? alt_mask_i : onehot;
    assign masked    = operand_i & mask;
    assign zf_o      = (masked == '0);
    assign nf_o      = masked[DATA_W-1];
    assign set_val_o = operand_i | onehot;
    assign clr_val_o = operand_i & ~onehot;

endmodule

// File: rtl/bit_rmw_seq.sv
module bit_rmw_seq
    import bit_rmw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int OFFS_W = 8,
    parameter logic [ADDR_W-1:0] IO_BASE = 16'h3F80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [1:0]        mode_i,
    input  logic [2:0]        bitpos_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] reg_i,
    input  logic [DATA_W-1:0] imm_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              zf_o,
    output logic              nf_o,
    output logic              cf_o,
    output logic              vf_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i
);

    localparam int POS_W = $clog2(DATA_W);

    typedef struct packed {
        state_e            st;
        op_e               op;
        logic [POS_W-1:0]  pos;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] held;
        logic              zf;
        logic              nf;
    } regs_t;

    regs_t r_d, r_q;

    logic [ADDR_W-1:0] ea;
    logic              accept;
    logic              at_rest;
    logic [DATA_W-1:0] operand;
    logic [POS_W-1:0]  pos_sel;
    logic [DATA_W-1:0] set_val, clr_val;
    logic              zf_calc, nf_calc;

    bit_rmw_addr #(
        .ADDR_W (ADDR_W),
        .OFFS_W (OFFS_W),
        .IO_BASE(IO_BASE)
    ) i_addr (
        .mode_i(amode_e'(mode_i)),
        .addr_i(addr_i),
        .ea_o  (ea)
    );

    assign at_rest = (r_q.st == ST_IDLE) || (r_q.st == ST_DONE);
    assign accept  = start_i && at_rest;

    // Operand: fresh read data, the held byte, or the register input.
    always_comb begin
        unique case (r_q.st)
            ST_WAIT:  operand = mem_rdata_i;
            ST_WRITE: operand = r_q.held;
            default:  operand = reg_i;
        endcase
    end

    assign pos_sel = r_q.pos;

    bit_rmw_bitlogic #(
        .DATA_W(DATA_W),
        .POS_W (POS_W)
    ) i_bits (
        .pos_i     (pos_sel),
        .operand_i (operand),
        .alt_mask_i(imm_i),
        .use_alt_i (at_rest),
        .set_val_o (set_val),
        .clr_val_o (clr_val),
        .zf_o      (zf_calc),
        .nf_o      (nf_calc)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE, ST_DONE: begin
                r_d.st = ST_IDLE;
                if (accept) begin
                    r_d.op   = op_e'(op_i);
                    r_d.pos  = POS_W'(bitpos_i);
                    r_d.addr = ea;
                    if (op_e'(op_i) == OP_TSTR) begin
                        r_d.st = ST_DONE;
                        r_d.zf = zf_calc;
                        r_d.nf = nf_calc;
                    end else begin
                        r_d.st = ST_READ;
                    end
                end
            end
            ST_READ: r_d.st = ST_WAIT;
            ST_WAIT: begin
                r_d.held = mem_rdata_i;
                if (r_q.op == OP_TSTM) begin
                    r_d.st = ST_DONE;
                    r_d.zf = zf_calc;
                    r_d.nf = nf_calc;
                end else begin
                    r_d.st = ST_WRITE;
                end
            end
            ST_WRITE: begin
                r_d.st = ST_DONE;
                r_d.zf = zf_calc;
                r_d.nf = nf_calc;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, op: OP_SET, pos: '0, addr: '0,
                     held: '0, zf: 1'b0, nf: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = (r_q.st == ST_READ) || (r_q.st == ST_WAIT) || (r_q.st == ST_WRITE);
    assign done_o      = (r_q.st == ST_DONE);
    assign mem_rd_o    = (r_q.st == ST_READ);
    assign mem_wr_o    = (r_q.st == ST_WRITE);
    assign mem_addr_o  = r_q.addr;
    assign mem_wdata_o = (r_q.op == OP_SET) ? set_val : clr_val;
    assign zf_o        = r_q.zf;
    assign nf_o        = r_q.nf;
    assign cf_o        = 1'b0;
    assign vf_o        = 1'b0;

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o)); // R6

    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> ($past(mem_rd_o, 2) && mem_addr_o == $past(mem_addr_o, 2))); // R4

    AST_WDATA_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> ($countones(mem_wdata_o ^ r_q.held) <= 1)); // R5

    AST_ZF_NF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && zf_o) |-> !nf_o); // R3

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(zf_o) && $stable(nf_o)) |-> done_o); // R11

    AST_BUSY_NO_RD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !mem_wr_o) |=> !mem_rd_o); // R9

endmodule

// File: tb/test_bit_rmw_seq.sv
module test_bit_rmw_seq;
    import bit_rmw_pkg::*;

    localparam logic [15:0] IO_BASE = 16'h3F80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [1:0]  mode_i = 2'b00;
    logic [2:0]  bitpos_i = 3'd0;
    logic [15:0] addr_i = 16'h0;
    logic [7:0]  reg_i = 8'h0;
    logic [7:0]  imm_i = 8'h0;
    logic        busy_o, done_o, zf_o, nf_o, cf_o, vf_o;
    logic [15:0] mem_addr_o;
    logic        mem_rd_o, mem_wr_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i = 8'h0;

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 1'b0;

    logic [7:0]  mem [logic [15:0]];
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [15:0] last_rd = 16'h0;
    logic [15:0] last_wr = 16'h0;

    always #5 clk = ~clk;

    bit_rmw_seq #(.IO_BASE(IO_BASE)) i_bit_rmw_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .mode_i(mode_i), .bitpos_i(bitpos_i), .addr_i(addr_i),
        .reg_i(reg_i), .imm_i(imm_i), .busy_o(busy_o), .done_o(done_o),
        .zf_o(zf_o), .nf_o(nf_o), .cf_o(cf_o), .vf_o(vf_o),
        .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
    );

    // Memory model: one-cycle read latency.
    always @(posedge clk) begin
        if (mem_rd_o) begin
            mem_rdata_i <= mem.exists(mem_addr_o) ? mem[mem_addr_o] : 8'h00;
            rd_cnt  = rd_cnt + 1;
            last_rd = mem_addr_o;
        end
        if (mem_wr_o) begin
            mem[mem_addr_o] = mem_wdata_o;
            wr_cnt  = wr_cnt + 1;
            last_wr = mem_addr_o;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drives a request at the current negedge and waits for done.
    task automatic run_op(input logic [1:0] op, input logic [1:0] mode,
                          input logic [2:0] pos, input logic [15:0] addr,
                          input logic [7:0] rv, input logic [7:0] iv,
                          input bit poke, output int cyc);
        rd_cnt = 0;
        wr_cnt = 0;
        op_i = op; mode_i = mode; bitpos_i = pos; addr_i = addr;
        reg_i = rv; imm_i = iv; start_i = 1'b1;
        @(negedge clk);
        cyc = 1;
        if (poke) begin
            op_i = 2'b00; addr_i = addr ^ 16'h0055; bitpos_i = ~pos;
        end else begin
            start_i = 1'b0;
        end
        while (!done_o && cyc < 20) begin
            @(negedge clk);
            cyc++;
            if (cyc == 2) start_i = 1'b0;
        end
        start_i = 1'b0;
    endtask

    function automatic logic [15:0] exp_addr(input logic [1:0] mode, input logic [15:0] a);
        case (mode)
            2'b00:   return IO_BASE + {8'h00, a[7:0]};
            2'b01:   return {8'h00, a[7:0]};
            default: return a;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0]  pats [4];
        logic [15:0] addrs [3];
        int run_idx;
        pats  = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
        addrs = '{16'h12C4, 16'hA07F, 16'h00FF};
        run_idx = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "done",  done_o, 0);
        check("R1", "busy",  busy_o, 0);
        check("R1", "rd",    mem_rd_o, 0);
        check("R1", "wr",    mem_wr_o, 0);
        check("R1", "flags", {zf_o, nf_o, cf_o, vf_o}, 4'b0000);

        for (int op = 0; op < 3; op++) begin
            for (int md = 0; md < 4; md++) begin
                for (int p = 0; p < 8; p++) begin
                    for (int k = 0; k < 4; k++) begin
                        for (int a = 0; a < 3; a++) begin
                            logic [15:0] ea;
                            logic [7:0]  m, pat, nv;
                            int cyc;
                            bit poke;
                            ea  = exp_addr(2'(md), addrs[a]);
                            pat = pats[k] ^ 8'(a * 8'h11);
                            m   = 8'h01 << p;
                            nv  = (op == 0) ? (pat | m) : (op == 1) ? (pat & ~m) : pat;
                            mem[ea] = pat;
                            poke = (run_idx % 5) == 3;
                            run_op(2'(op), 2'(md), 3'(p), addrs[a], 8'h00, 8'h00, poke, cyc);
                            check("R3", "zf", zf_o, ((pat & m) == 8'h00));
                            check("R3", "nf", nf_o, pat[7] & m[7]);
                            check("R3", "cf_vf", {cf_o, vf_o}, 2'b00);
                            check("R2", "read addr", last_rd, ea);
                            check("R9", "read count", rd_cnt, 1);
                            if (op == 0) begin
                                check("R4", "set byte", mem[ea], nv);
                                check("R4", "write count", wr_cnt, 1);
                                check("R2", "write addr", last_wr, ea);
                                check("R8", "latency", cyc, 4);
                            end else if (op == 1) begin
                                check("R5", "clear byte", mem[ea], nv);
                                check("R5", "write count", wr_cnt, 1);
                                check("R2", "write addr", last_wr, ea);
                                check("R8", "latency", cyc, 4);
                            end else begin
                                check("R6", "byte kept", mem[ea], pat);
                                check("R6", "write count", wr_cnt, 0);
                                check("R8", "latency", cyc, 3);
                            end
                            if (run_idx % 2 == 0) begin
                                logic zs, ns;
                                zs = zf_o; ns = nf_o;
                                @(negedge clk);
                                check("R8", "done pulse", done_o, 0);
                                check("R11", "flags held", {zf_o, nf_o}, {zs, ns});
                            end
                            // odd runs go back-to-back from the done cycle (R10)
                            run_idx++;
                        end
                    end
                end
            end
        end

        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                logic [7:0] rv, iv, mk;
                int cyc;
                rv = 8'(x * 8'h1B) ^ 8'(x << 4);
                iv = 8'(y * 8'h35) ^ 8'(y << 5);
                mk = rv & iv;
                run_op(2'b11, 2'(y % 4), 3'(x % 8), 16'h1234, rv, iv, 1'b0, cyc);
                check("R7", "zf", zf_o, (mk == 8'h00));
                check("R7", "nf", nf_o, mk[7]);
                check("R7", "cf_vf", {cf_o, vf_o}, 2'b00);
                check("R7", "latency", cyc, 1);
                check("R7", "no access", rd_cnt + wr_cnt, 0);
                if (y % 3 == 0) begin
                    @(negedge clk);
                    check("R10", "idle after", {done_o, busy_o}, 2'b00);
                end
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule